// File: doc/BRIEF.md
# Banked Carry/Zero Flag File

This block holds the carry and zero status flags of a small processor core in three separate banks, one for each execution context: main program, maskable interrupt handler and non-maskable interrupt handler. The bank in use is chosen by the current context, which the block tracks on its own. A strobe for maskable interrupt entry, a strobe for non-maskable interrupt entry and a strobe for return-from-interrupt move the context. Flag writes from the ALU always go to the bank that is active in that cycle.

A short history of interrupted contexts is kept inside the block. A return therefore resumes the context that was interrupted, including the nested case where a non-maskable interrupt arrives inside a maskable handler. The block comes out of reset in the non-maskable context, and every flag starts cleared. Banks are never cleared on a switch, so each handler sees its own flags exactly as it left them. The ALU computes the flag values: carry on carry or borrow, carry as the tested bit for bit tests, zero on a zero result. This block only stores and selects them.

Top module: `banked_flag_file`

## Requirements
- R1: After synchronous reset, `ctx_o` is 2 (non-maskable context) and `carry_o` and `zero_o` are 0. All three banks hold 0.
- R2: When `irq_enter` is high and `nmi_enter` is low at a clock edge, `ctx_o` becomes 1 (maskable interrupt context) after that edge. The flag outputs then show the interrupt bank.
- R3: When `nmi_enter` is high at a clock edge, `ctx_o` becomes 2 after that edge. The flag outputs then show the non-maskable bank.
- R4: Each entry saves the context it leaves. When `reti` is high alone, the most recently saved context is restored, including its flags. A non-maskable entry made from interrupt context therefore returns to context 1.
- R5: When `reti` is high alone and no saved context remains, the context becomes 0 (main program).
- R6: A flag write changes only the active bank. Inactive banks keep their values through any number of switches.
- R7: `c_wr` loads `c_in` into the active carry flag, and `z_wr` loads `z_in` into the active zero flag. Each enable acts on its own flag only.
- R8: If several strobes are high in the same cycle, `nmi_enter` takes priority over `irq_enter`, and `irq_enter` takes priority over `reti`. A strobe that loses has no effect.
- R9: A flag write in the same cycle as a context switch goes to the bank of the context that was active before the switch.
- R10: The history holds two saved contexts. A third nested entry discards the oldest one, and returns then yield the two newest in reverse order, followed by context 0.
- R11: All outputs are registered. A change caused by the inputs at a clock edge appears just after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_wr | input | 1 | Write enable for the active carry flag |
| z_wr | input | 1 | Write enable for the active zero flag |
| c_in | input | 1 | New carry value from the ALU |
| z_in | input | 1 | New zero value from the ALU |
| irq_enter | input | 1 | Maskable interrupt entry strobe |
| nmi_enter | input | 1 | Non-maskable interrupt entry strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| carry_o | output | 1 | Carry flag of the active bank |
| zero_o | output | 1 | Zero flag of the active bank |
| ctx_o | output | 2 | Current context: 0 main, 1 interrupt, 2 non-maskable |

## Verification
Two things can fall in the same cycle: a flag write and a context switch. The write must land in the bank being left, while the outputs already show the bank being entered. The bench forces this case with directed writes issued together with entry and return strobes. It also produces it many times in a long pseudo-random sweep where writes and strobes overlap freely. Every cycle is judged against a bench model that keeps three banks and a two-deep history, with the priority rule applied to strobes that collide.

// File: rtl/bff_pkg.sv
package bff_pkg;
  localparam int CTX_W   = 2;
  localparam int NUM_CTX = 3;

  typedef enum logic [CTX_W-1:0] {
    CTX_MAIN = 2'd0,
    CTX_IRQ  = 2'd1,
    CTX_NMI  = 2'd2
  } ctx_e;

  localparam logic [CTX_W-1:0] CTX_RESET = CTX_NMI;
endpackage

// File: rtl/bff_history.sv
module bff_history #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val,
  output logic         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign top_val = slot_q[0];
  assign empty   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push) begin
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q[0] <= '0;
    else if (push) slot_q[0] <= push_val;
    else if (pop && !empty) slot_q[0] <= (DEPTH > 1) ? slot_q[(DEPTH > 1) ? 1 : 0] : '0;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= '0;
      else if (push) slot_q[i] <= slot_q[i-1];
      else if (pop && !empty) slot_q[i] <= (i + 1 < DEPTH) ? slot_q[(i + 1 < DEPTH) ? i + 1 : i] : '0;
    end
  end
endmodule

// File: rtl/bff_ctx_ctrl.sv
module bff_ctx_ctrl
  import bff_pkg::*;
#(
  parameter int HIST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_enter,
  input  logic             nmi_enter,
  input  logic             reti,
  output logic [CTX_W-1:0] ctx_q,
  output logic [CTX_W-1:0] ctx_nxt,
  output logic             hist_empty
);
  logic             do_push;
  logic             do_pop;
  logic [CTX_W-1:0] saved_ctx;

  assign do_push = nmi_enter | irq_enter;
  assign do_pop  = reti & ~do_push;

  bff_history #(.DEPTH(HIST_DEPTH), .W(CTX_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .push     (do_push),
    .pop      (do_pop),
    .push_val (ctx_q),
    .top_val  (saved_ctx),
    .empty    (hist_empty)
  );

  always_comb begin
    ctx_nxt = ctx_q;
    if (nmi_enter)      ctx_nxt = CTX_NMI;
    else if (irq_enter) ctx_nxt = CTX_IRQ;
    else if (reti)      ctx_nxt = hist_empty ? CTX_MAIN : saved_ctx;
  end

  always_ff @(posedge clk) begin
    if (rst) ctx_q <= CTX_RESET;
    else     ctx_q <= ctx_nxt;
  end
endmodule

// File: rtl/bff_banks.sv
module bff_banks #(
  parameter int NUM = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             c_wr,
  input  logic             z_wr,
  input  logic             c_in,
  input  logic             z_in,
  output logic [NUM-1:0]   c_nxt,
  output logic [NUM-1:0]   z_nxt
);
  logic [NUM-1:0] c_q;
  logic [NUM-1:0] z_q;

  for (genvar i = 0; i < NUM; i++) begin : g_bank
    logic hit;
    assign hit      = (wr_sel == SEL_W'(i));
    assign c_nxt[i] = (hit && c_wr) ? c_in : c_q[i];
    assign z_nxt[i] = (hit && z_wr) ? z_in : z_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        c_q[i] <= 1'b0;
        z_q[i] <= 1'b0;
      end else begin
        c_q[i] <= c_nxt[i];
        z_q[i] <= z_nxt[i];
      end
    end
  end
endmodule

// File: rtl/banked_flag_file.sv
module banked_flag_file
  import bff_pkg::*;
#(
  parameter int HIST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             c_wr,
  input  logic             z_wr,
  input  logic             c_in,
  input  logic             z_in,
  input  logic             irq_enter,
  input  logic             nmi_enter,
  input  logic             reti,
  output logic             carry_o,
  output logic             zero_o,
  output logic [CTX_W-1:0] ctx_o
);
  logic [CTX_W-1:0]   ctx_q;
  logic [CTX_W-1:0]   ctx_nxt;
  logic               hist_empty;
  logic [NUM_CTX-1:0] c_nxt;
  logic [NUM_CTX-1:0] z_nxt;

  bff_ctx_ctrl #(.HIST_DEPTH(HIST_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .irq_enter  (irq_enter),
    .nmi_enter  (nmi_enter),
    .reti       (reti),
    .ctx_q      (ctx_q),
    .ctx_nxt    (ctx_nxt),
    .hist_empty (hist_empty)
  );

  bff_banks #(.NUM(NUM_CTX), .SEL_W(CTX_W)) u_banks (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (ctx_q),
    .c_wr   (c_wr),
    .z_wr   (z_wr),
    .c_in   (c_in),
    .z_in   (z_in),
    .c_nxt  (c_nxt),
    .z_nxt  (z_nxt)
  );

  function automatic logic pick(input logic [NUM_CTX-1:0] v, input logic [CTX_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_CTX; i++)
      if (s == CTX_W'(i)) r = v[i];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else begin
      carry_o <= pick(c_nxt, ctx_nxt);
      zero_o  <= pick(z_nxt, ctx_nxt);
    end
  end

  assign ctx_o = ctx_q;
endmodule

// File: rtl/banked_flag_file_chk.sv
module banked_flag_file_chk (
  input logic       clk,
  input logic       rst,
  input logic       c_wr,
  input logic       z_wr,
  input logic       c_in,
  input logic       z_in,
  input logic       irq_enter,
  input logic       nmi_enter,
  input logic       reti,
  input logic       carry_o,
  input logic       zero_o,
  input logic [1:0] ctx_o,
  input logic       hist_empty
);
  // R1
  ctx_legal_chk: assert property (@(posedge clk) disable iff (rst) ctx_o != 2'd3);
  // R2
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && !nmi_enter) |=> ctx_o == 2'd1);
  // R3
  nmi_entry_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_enter |=> ctx_o == 2'd2);
  // R5
  empty_return_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !irq_enter && !nmi_enter && hist_empty) |=> ctx_o == 2'd0);
  // R7
  carry_load_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && !irq_enter && !nmi_enter && !reti) |=> carry_o == $past(c_in));
  // R7
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (z_wr && !irq_enter && !nmi_enter && !reti) |=> zero_o == $past(z_in));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!c_wr && !z_wr && !irq_enter && !nmi_enter && !reti) |=>
      ($stable(carry_o) && $stable(zero_o) && $stable(ctx_o)));
endmodule

bind banked_flag_file banked_flag_file_chk u_chk (.*);

// File: tb/banked_flag_file_tb.sv
module banked_flag_file_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c_wr = 0, z_wr = 0, c_in = 0, z_in = 0;
  logic irq_enter = 0, nmi_enter = 0, reti = 0;
  logic carry_o, zero_o;
  logic [1:0] ctx_o;

  int checks = 0;
  int errors = 0;

  bit mc [3];
  bit mz [3];
  int mctx;
  int hist [2];
  int hcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_flag_file u_dut (
    .clk(clk), .rst(rst), .c_wr(c_wr), .z_wr(z_wr), .c_in(c_in), .z_in(z_in),
    .irq_enter(irq_enter), .nmi_enter(nmi_enter), .reti(reti),
    .carry_o(carry_o), .zero_o(zero_o), .ctx_o(ctx_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " ctx"}, ctx_o, mctx);
    check({tag, " carry"}, carry_o, mc[mctx]);
    check({tag, " zero"}, zero_o, mz[mctx]);
  endtask

  task automatic model_push(input int nc);
    hist[1] = hist[0];
    hist[0] = mctx;
    if (hcnt < 2) hcnt++;
    mctx = nc;
  endtask

  task automatic step(input bit cw, input bit zw, input bit ci, input bit zi,
                      input bit irq, input bit nmi, input bit rt);
    c_wr = cw; z_wr = zw; c_in = ci; z_in = zi;
    irq_enter = irq; nmi_enter = nmi; reti = rt;
    @(posedge clk);
    if (cw) mc[mctx] = ci;
    if (zw) mz[mctx] = zi;
    if (nmi) model_push(2);
    else if (irq) model_push(1);
    else if (rt) begin
      if (hcnt > 0) begin
        mctx = hist[0];
        hist[0] = hist[1];
        hcnt--;
      end else mctx = 0;
    end
    @(negedge clk);
    c_wr = 0; z_wr = 0; irq_enter = 0; nmi_enter = 0; reti = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 3; i++) begin mc[i] = 0; mz[i] = 0; end
    mctx = 2; hcnt = 0; hist[0] = 0; hist[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");
    check("R1 literal ctx", ctx_o, 2);

    step(1, 1, 1, 1, 0, 0, 0); check_all("R7 both");
    step(1, 0, 0, 1, 0, 0, 0); check_all("R7 carry only");
    check("R7 literal zero kept", zero_o, 1);
    step(0, 1, 0, 0, 0, 0, 0); check_all("R7 zero only");
    step(0, 1, 0, 1, 0, 0, 0); check_all("R7 zero again");

    // R11: outputs must not move before the edge
    irq_enter = 1;
    #1 check("R11 ctx before edge", ctx_o, 2);
    irq_enter = 0;

    step(0, 0, 0, 0, 1, 0, 0); check_all("R2 enter");
    check("R2 literal carry", carry_o, 0);
    step(1, 1, 1, 0, 0, 0, 0); check_all("R6 write irq bank");
    step(1, 0, 0, 0, 0, 1, 0); check_all("R9 write with nmi entry");
    check("R3 literal zero of nmi bank", zero_o, 1);
    step(0, 0, 0, 0, 0, 0, 1); check_all("R4 return to irq");
    check("R9 literal carry landed in irq bank", carry_o, 0);
    step(0, 0, 0, 0, 0, 0, 1); check_all("R4 return to nmi");
    step(0, 0, 0, 0, 0, 0, 1); check_all("R5 empty return");
    check("R5 literal ctx", ctx_o, 0);
    step(0, 0, 0, 0, 0, 0, 1); check_all("R5 empty again");

    step(0, 0, 0, 0, 1, 1, 1); check_all("R8 all strobes");
    check("R8 literal ctx", ctx_o, 2);
    step(0, 0, 0, 0, 1, 0, 1); check_all("R8 irq over reti");
    step(0, 0, 0, 0, 1, 0, 0); check_all("R10 third push");
    step(0, 0, 0, 0, 0, 0, 1); check_all("R10 pop one");
    check("R10 literal first pop", ctx_o, 1);
    step(0, 0, 0, 0, 0, 0, 1); check_all("R10 pop two");
    check("R10 literal second pop", ctx_o, 2);
    step(0, 0, 0, 0, 0, 0, 1); check_all("R10 oldest dropped");
    check("R10 literal empty", ctx_o, 0);

    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      bit irq, nmi, rt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq = (lfsr[2:0] == 3'd0);
      nmi = (lfsr[6:4] == 3'd1) && lfsr[9];
      rt  = (lfsr[12:10] == 3'd2) || (lfsr[12:10] == 3'd5);
      step(lfsr[3], lfsr[7], lfsr[8], lfsr[11], irq, nmi, rt);
      check_all("R6 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule